// File: doc/BRIEF.md
# Supervisory Reset Controller with Margin Hold

The block combines several fault sources into one active-low system reset. Its sources are a vector of undervoltage flags (one bit per monitored supply, high meaning that supply is below its threshold), an active-low manual reset button and a single-cycle watchdog-expiry pulse. The reset asserts while any source is active. It stays asserted for a programmable stretch period after the last source has cleared. All inputs are synchronous to the block clock, and every time interval is a parameterised count of clock cycles.

A manual reset counts only after it has been held low for a qualification time. A shorter press has no effect. An active-low margin input freezes the reset output and its stretch timer at their present values. This lets system tests run with supplies outside their normal range. Margin takes priority over manual reset. Boards that do not use margin tie it high. When margin is released, evaluation resumes on the next clock, and any cause still present acts at once.

Top module: `sup_reset_ctrl`

## Requirements
- R1: After `rst_ni` is released with no cause present, `rst_no` reads 0 and rises to 1 at the STRETCH_CYC-th rising clock edge after release.
- R2: With margin inactive, any bit of `uv_flags_i` at 1 on a rising edge makes `rst_no` 0 after that edge. Every bit position acts alone.
- R3: A manual-reset press held low for fewer than MR_QUAL_CYC consecutive edges never asserts reset. Returning high clears the qualification count, so two short presses do not add up.
- R4: `mr_ni` held low on MR_QUAL_CYC consecutive edges qualifies. Reset is then 0 after the next edge while the press lasts.
- R5: A one-cycle pulse of `wdt_exp_i` (1 = expired) asserts reset after the edge that samples it.
- R6: Once no cause is present, `rst_no` stays 0 and rises at the STRETCH_CYC-th consecutive cause-free edge.
- R7: A cause that appears while the stretch is running restarts the stretch from zero.
- R8: While `margin_ni` is 0, `rst_no` does not change, whether it is high or low. Manual reset and the other causes are ignored, and the stretch count is frozen.
- R9: When `margin_ni` returns to 1, a cause still present asserts reset after the next edge. A frozen stretch resumes from the count at which it was frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, the timebase for all counts |
| rst_ni | input | 1 | Asynchronous active-low logic reset |
| uv_flags_i | input | NUM_UV | Undervoltage flags, 1 = supply below threshold |
| mr_ni | input | 1 | Manual reset request, active low |
| wdt_exp_i | input | 1 | Watchdog expiry pulse, active high |
| margin_ni | input | 1 | Margin hold, active low; tie high if unused |
| rst_no | output | 1 | System reset, active low |

## Verification
Each undervoltage bit is raised alone, and a one-cycle watchdog pulse is applied, to show that every source reaches the output. Manual-reset presses are split into two sub-threshold pieces and compared with a press that just reaches the threshold; this separates a counter that clears from one that accumulates, and locates the exact qualifying edge. A second cause injected midway through the stretch distinguishes restart from continue. Margin is applied once with the output high (while manual reset and undervoltage are active) and once during a stretch. This shows that the freeze holds both levels and the timer count, and that pending causes act on the first edge after release.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
  typedef enum logic [1:0] {
    PH_ACTIVE   = 2'd0,
    PH_STRETCH  = 2'd1,
    PH_RELEASED = 2'd2
  } rst_phase_e;
endpackage

// File: rtl/sup_mr_qual.sv
module sup_mr_qual #(
  parameter int unsigned MR_QUAL_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mr_ni,
  output logic mr_valid_o
);
  localparam int unsigned CW = $clog2(MR_QUAL_CYC + 1);
  localparam logic [CW-1:0] QMAX = CW'(MR_QUAL_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (mr_ni)       cnt_q <= '0;           // early release clears
    else if (cnt_q != QMAX) cnt_q <= cnt_q + 1'b1;
  end

  assign mr_valid_o = !mr_ni && (cnt_q == QMAX);

  p_mr_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_ni |=> (cnt_q == '0));
  p_mr_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= QMAX);
endmodule

// File: rtl/sup_cause_merge.sv
module sup_cause_merge #(
  parameter int unsigned NUM_UV = 6
) (
  input  logic [NUM_UV-1:0] uv_flags_i,
  input  logic              mr_valid_i,
  input  logic              wdt_exp_i,
  output logic              cause_o
);
  assign cause_o = (|uv_flags_i) | mr_valid_i | wdt_exp_i;
endmodule

// File: rtl/sup_stretch_ctrl.sv
module sup_stretch_ctrl
  import sup_rst_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic cause_i,
  output logic rst_no
);
  localparam int unsigned SW = (STRETCH_CYC > 1) ? $clog2(STRETCH_CYC) : 1;
  localparam logic [SW-1:0] LAST = SW'(STRETCH_CYC - 1);

  rst_phase_e    phase_q;
  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ACTIVE;
      cnt_q   <= '0;
    end else if (hold_i) begin
      phase_q <= phase_q;
      cnt_q   <= cnt_q;
    end else if (cause_i) begin
      phase_q <= PH_ACTIVE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_ACTIVE, PH_STRETCH: begin
          if (cnt_q == LAST) begin
            phase_q <= PH_RELEASED;
            cnt_q   <= '0;
          end else begin
            phase_q <= PH_STRETCH;
            cnt_q   <= cnt_q + 1'b1;
          end
        end
        default: begin
          phase_q <= PH_RELEASED;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign rst_no = (phase_q == PH_RELEASED);

  p_hold_phase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ($stable(phase_q) && $stable(cnt_q)));
  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && cause_i) |=> (cnt_q == '0 && phase_q == PH_ACTIVE));
  p_release_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> (!$past(cause_i) && !$past(hold_i)));
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int unsigned NUM_UV      = 6,
  parameter int unsigned MR_QUAL_CYC = 50,
  parameter int unsigned STRETCH_CYC = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_UV-1:0] uv_flags_i,
  input  logic              mr_ni,
  input  logic              wdt_exp_i,
  input  logic              margin_ni,
  output logic              rst_no
);
  logic mr_valid;
  logic cause;
  logic hold;

  assign hold = !margin_ni;

  sup_mr_qual #(.MR_QUAL_CYC(MR_QUAL_CYC)) u_mr_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mr_ni      (mr_ni),
    .mr_valid_o (mr_valid)
  );

  sup_cause_merge #(.NUM_UV(NUM_UV)) u_merge (
    .uv_flags_i (uv_flags_i),
    .mr_valid_i (mr_valid),
    .wdt_exp_i  (wdt_exp_i),
    .cause_o    (cause)
  );

  sup_stretch_ctrl #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (hold),
    .cause_i (cause),
    .rst_no  (rst_no)
  );

  p_margin_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !margin_ni |=> $stable(rst_no));
  p_uv_asserts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (margin_ni && |uv_flags_i) |=> !rst_no);
  p_wdt_asserts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (margin_ni && wdt_exp_i) |=> !rst_no);
endmodule

// File: tb/sup_reset_ctrl_test.sv
module sup_reset_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_UV     = 6;
  localparam int MRQ        = 8;
  localparam int STR        = 20;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic [NUM_UV-1:0] uv_flags;
  logic              mr_n, wdt, margin_n;
  logic              rst_n_out;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sup_reset_ctrl #(.NUM_UV(NUM_UV), .MR_QUAL_CYC(MRQ), .STRETCH_CYC(STR)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .uv_flags_i(uv_flags), .mr_ni(mr_n),
    .wdt_exp_i(wdt), .margin_ni(margin_n), .rst_no(rst_n_out)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp);
    checks++;
    if (rst_n_out !== exp) begin
      failures++;
      $display("FAIL %s rst_no=%b expected=%b t=%0t", req, rst_n_out, exp, $time);
    end
  endtask

  task automatic t_por_r1;
    rst_ni = 1'b0; uv_flags = '0; mr_n = 1'b1; wdt = 1'b0; margin_n = 1'b1;
    step(3);
    rst_ni = 1'b1;
    chk("R1 reset state", 1'b0);
    step(STR - 1); chk("R1 before release", 1'b0);
    step(1);       chk("R1 release", 1'b1);
  endtask

  task automatic t_uv_r2;
    for (int b = 0; b < NUM_UV; b++) begin
      uv_flags = '0; uv_flags[b] = 1'b1;
      step(1); chk("R2 uv bit asserts", 1'b0);
      uv_flags = '0;
      step(STR - 1); chk("R6 still stretched", 1'b0);
      step(1);       chk("R6 released", 1'b1);
    end
  endtask

  task automatic t_wdt_r5;
    wdt = 1'b1; step(1); wdt = 1'b0;
    chk("R5 wdt asserts", 1'b0);
    step(STR - 1); chk("R5 stretch", 1'b0);
    step(1);       chk("R5 release", 1'b1);
  endtask

  task automatic t_mr_short_r3;
    mr_n = 1'b0; step(MRQ - 1);
    mr_n = 1'b1; step(1);
    mr_n = 1'b0; step(MRQ - 1);
    mr_n = 1'b1; step(2);
    chk("R3 short presses ignored", 1'b1);
  endtask

  task automatic t_mr_qual_r4;
    mr_n = 1'b0;
    step(MRQ); chk("R4 not yet qualified", 1'b1);
    step(1);   chk("R4 qualified", 1'b0);
    mr_n = 1'b1;
    step(STR - 1); chk("R4 stretch after release", 1'b0);
    step(1);       chk("R4 released", 1'b1);
  endtask

  task automatic t_restart_r7;
    uv_flags[0] = 1'b1; step(1); uv_flags = '0;
    step(STR / 2);
    uv_flags[1] = 1'b1; step(1); uv_flags = '0;
    step(STR - 1); chk("R7 restarted stretch", 1'b0);
    step(1);       chk("R7 released", 1'b1);
  endtask

  task automatic t_margin_high_r8;
    margin_n = 1'b0;
    mr_n = 1'b0;
    step(MRQ + 3); chk("R8 margin overrides mr", 1'b1);
    uv_flags[2] = 1'b1;
    step(2); chk("R8 margin holds high", 1'b1);
    mr_n = 1'b1; margin_n = 1'b1;
    step(1); chk("R9 pending uv acts", 1'b0);
    uv_flags = '0;
    step(STR); chk("R9 released after stretch", 1'b1);
  endtask

  task automatic t_margin_low_r8;
    wdt = 1'b1; step(1); wdt = 1'b0;
    step(3);
    margin_n = 1'b0;
    step(STR + 5); chk("R8 margin holds low", 1'b0);
    margin_n = 1'b1;
    step(STR - 4); chk("R9 frozen count resumes", 1'b0);
    step(1);       chk("R9 resumed release", 1'b1);
  endtask

  initial begin
    fork
      begin
        t_por_r1;
        t_uv_r2;
        t_wdt_r5;
        t_mr_short_r3;
        t_mr_qual_r4;
        t_restart_r7;
        t_margin_high_r8;
        t_margin_low_r8;
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule